// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a two-wire bus target that behaves like a serial EEPROM on the bus. It oversamples the clock and data lines with the system clock, finds start and stop conditions, and decodes a device address byte against a fixed family code and two strap inputs, so that up to four such targets can share one bus. Once addressed in write mode it takes a two-byte word address, then stores data bytes into a byte-wide synchronous RAM. The RAM stands in for the nonvolatile array. Once addressed in read mode it returns data from a persistent address counter.

Reads come in three kinds. A current-address read returns the byte at the counter. A random read is a write that carries only the word address, followed by a repeated start and a read. A sequential read goes on for as long as the controller acknowledges each byte. When a write transaction that stored data ends, a commit timer marks the part busy for a fixed number of clocks. While it is busy, the block refuses its own address, so a controller can poll for completion. The only bus output is a pull-down enable for the open-drain data line.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The device address byte is sent MSB first. Bits [7:3] must equal DEV_ID (default 5'b10100), bits [2:1] must equal `strap_i`, and bit [0] selects the operation (1 = read, 0 = write). On a match with no commit in progress, the block pulls SDA low during the ninth clock.
- R2: If either the family code or the strap bits differ, the block does not acknowledge. It then leaves SDA released for every following bit until the next start condition.
- R3: In write mode, two word-address bytes follow the device byte, high byte first, and each is acknowledged. Only the low ADDR_W bits of that 16-bit value select a location; the upper bits are ignored.
- R4: Each data byte of a write is acknowledged and stored at the address counter. The counter's low PAGE_W bits then increment and wrap inside the same page, and the upper bits stay fixed.
- R5: The address counter persists between transactions and holds the last accessed location plus one. A current-address read returns the byte at the counter.
- R6: A random read works as follows. A write-mode header loads the word address, a repeated start follows, and a read-mode device byte then returns data starting at the loaded address.
- R7: During a read, a controller ACK (SDA low in the ninth clock) makes the block send the byte at the next address. The read address wraps from the last array location to 0. A controller NACK ends the read with SDA released.
- R8: A start or stop that ends a transaction in which at least one data byte was stored starts a commit lasting WR_CYCLES clocks. While the commit runs, the device address is not acknowledged. After it ends, the address is acknowledged again.
- R9: The block changes its SDA pull only while SCL is low, never while SCL is high.
- R10: After reset the block releases SDA and is not busy, so the first matching device address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap_i | input | 2 | Board strap value matched against device address bits [2:1] |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release (open-drain enable) |

## Verification
The bench targets several corner cases.
- A page write that starts near the end of a page must wrap back to the page start. A counter that carries into the next page would corrupt the neighbouring page, and the model readback would expose it.
- A sequential read across the top of the array must continue at location 0. A design that applied the page wrap to reads would return the wrong bytes.
- Polling right after a stop must see a NACK, and polling must be answered after the commit ends. A design that acknowledged while busy, or never recovered, fails either probe.
- Wrong strap bits must leave the bus untouched even across the following byte.
- A bus monitor watches for any pull change while SCL is high.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DEV,
      S_DEV_ACK,
      S_AHI,
      S_AHI_ACK,
      S_ALO,
      S_ALO_ACK,
      S_WDAT,
      S_WDAT_ACK,
      S_RDAT,
      S_RACK
   } eep_state_t;

   localparam int BYTE_BITS = 8;

endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("eep_line_sense: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic                   scl_p, sda_p;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
         end else begin
            scl_pipe <= scl_i;
            sda_pipe <= sda_i;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
         end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         end
      end
   end

   assign scl_s = scl_pipe[SYNC_STAGES-1];
   assign sda_s = sda_pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eep_commit_timer.sv
module eep_commit_timer #(
   parameter int WR_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);

   if (WR_CYCLES < 1) begin : g_bad_cycles
      $error("eep_commit_timer: WR_CYCLES must be at least 1");
   end

   localparam int CW = $clog2(WR_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (kick)
         cnt <= LOAD;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R8: a commit request always produces a busy period
   p_kick_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> busy);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
   import eep_pkg::*;
#(
   parameter int         ADDR_W      = 10,
   parameter int         PAGE_W      = 6,
   parameter logic [4:0] DEV_ID      = 5'b10100,
   parameter int         WR_CYCLES   = 5000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_i,
   output logic       sda_pull_o
);

   if (ADDR_W <= PAGE_W || ADDR_W > 16) begin : g_bad_addr
      $error("eeprom_i2c_target: need PAGE_W < ADDR_W <= 16");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("eeprom_i2c_target: PAGE_W must be at least 1");
   end

   localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);
   localparam logic [PAGE_W-1:0] ONE_P   = PAGE_W'(1);
   localparam logic [3:0]        LASTBIT = 4'(BYTE_BITS);

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic busy, kick, we, byte_in, dev_hit;

   eep_state_t        st;
   logic [3:0]        bitcnt;
   logic [7:0]        rx_sr, tx_sr, addr_hi, rd_q;
   logic              rw_q, ack_q, wrote_q, pull_q;
   logic [ADDR_W-1:0] ptr;

   eep_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev)
   );

   eep_commit_timer #(.WR_CYCLES(WR_CYCLES)) u_commit (
      .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
   );

   eep_array #(.ADDR_W(ADDR_W)) u_array (
      .clk(clk), .we(we), .waddr(ptr), .wdata(rx_sr), .raddr(ptr), .rdata(rd_q)
   );

   assign byte_in = scl_fall && (bitcnt == LASTBIT);
   assign dev_hit = (rx_sr[7:3] == DEV_ID) && (rx_sr[2:1] == strap_i) && !busy;
   assign we      = (st == S_WDAT) && byte_in;
   assign kick    = (start_ev || stop_ev) && wrote_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         bitcnt  <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
         addr_hi <= '0;
         rw_q    <= 1'b0;
         ack_q   <= 1'b0;
         wrote_q <= 1'b0;
         pull_q  <= 1'b0;
         ptr     <= '0;
      end else if (start_ev) begin
         st      <= S_DEV;
         bitcnt  <= '0;
         pull_q  <= 1'b0;
         wrote_q <= 1'b0;
      end else if (stop_ev) begin
         st      <= S_IDLE;
         pull_q  <= 1'b0;
         wrote_q <= 1'b0;
      end else begin
         unique case (st)
            S_DEV, S_AHI, S_ALO, S_WDAT: begin
               if (scl_rise) begin
                  rx_sr  <= {rx_sr[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_in) begin
                  bitcnt <= '0;
                  pull_q <= 1'b1;
                  unique case (st)
                     S_DEV: begin
                        rw_q <= rx_sr[0];
                        if (dev_hit) st <= S_DEV_ACK;
                        else begin
                           st     <= S_IDLE;
                           pull_q <= 1'b0;
                        end
                     end
                     S_AHI: begin
                        addr_hi <= rx_sr;
                        st      <= S_AHI_ACK;
                     end
                     S_ALO: begin
                        ptr <= ADDR_W'({addr_hi, rx_sr});
                        st  <= S_ALO_ACK;
                     end
                     default: begin
                        wrote_q <= 1'b1;
                        ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + ONE_P};
                        st      <= S_WDAT_ACK;
                     end
                  endcase
               end
            end
            S_DEV_ACK: if (scl_fall) begin
               if (rw_q) begin
                  tx_sr  <= rd_q;
                  pull_q <= ~rd_q[7];
                  st     <= S_RDAT;
               end else begin
                  pull_q <= 1'b0;
                  st     <= S_AHI;
               end
            end
            S_AHI_ACK: if (scl_fall) begin
               pull_q <= 1'b0;
               st     <= S_ALO;
            end
            S_ALO_ACK, S_WDAT_ACK: if (scl_fall) begin
               pull_q <= 1'b0;
               st     <= S_WDAT;
            end
            S_RDAT: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_in) begin
                  bitcnt <= '0;
                  pull_q <= 1'b0;
                  ptr    <= ptr + ONE_A;
                  st     <= S_RACK;
               end else if (scl_fall) begin
                  tx_sr  <= {tx_sr[6:0], 1'b0};
                  pull_q <= ~tx_sr[6];
               end
            end
            S_RACK: begin
               if (scl_rise) begin
                  ack_q <= ~sda_s;
               end else if (scl_fall) begin
                  if (ack_q) begin
                     tx_sr  <= rd_q;
                     pull_q <= ~rd_q[7];
                     st     <= S_RDAT;
                  end else begin
                     st <= S_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_pull_o = pull_q;

   // R9: the pull only moves while the sampled clock line is low
   p_pull_low_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_o != $past(sda_pull_o)) |-> !scl_s);

   // R4: a stored byte never moves the counter to another page
   p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

   // R8: an address byte that arrives during a commit leaves the bus alone
   p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEV && byte_in && busy) |=> (st == S_IDLE && !sda_pull_o));

   // R8: nothing is stored while a commit runs
   p_no_store_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !busy);

endmodule

// File: tb/eeprom_i2c_target_bench.sv
module eeprom_i2c_target_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int PW    = 6;
   localparam int DEPTH = 1 << AW;
   localparam int PAGE  = 1 << PW;
   localparam int WRC   = 400;
   localparam int Q     = 6;
   localparam int WD    = 190000;
   localparam logic [1:0] STRAP = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic c_scl = 1'b1;
   logic c_sda = 1'b1;
   logic sda_pull;
   logic bus_sda;

   int n_cmp = 0;
   int n_bad = 0;
   int viol = 0;
   logic prev_pull = 1'b0;

   logic [7:0] ref_mem [DEPTH];
   int ref_ptr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign bus_sda = c_sda & ~sda_pull;

   eeprom_i2c_target #(
      .ADDR_W(AW), .PAGE_W(PW), .DEV_ID(5'b10100), .WR_CYCLES(WRC), .SYNC_STAGES(2)
   ) u_eeprom_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(c_scl), .sda_i(bus_sda),
      .strap_i(STRAP), .sda_pull_o(sda_pull)
   );

   // R9 bus monitor: pull must not move while the controller holds SCL high
   always @(negedge clk) begin
      if (rst_n && c_scl && (sda_pull !== prev_pull)) viol++;
      prev_pull = sda_pull;
   end

   function automatic int page_next(input int a);
      return (a & ~(PAGE - 1)) | ((a + 1) & (PAGE - 1));
   endfunction

   function automatic logic [7:0] dev_byte(input logic rd);
      return {5'b10100, STRAP, rd};
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      c_sda = 1'b1; hold(Q);
      c_scl = 1'b1; hold(Q);
      c_sda = 1'b0; hold(Q);
      c_scl = 1'b0; hold(Q);
   endtask

   task automatic bus_stop();
      c_sda = 1'b0; hold(Q);
      c_scl = 1'b1; hold(Q);
      c_sda = 1'b1; hold(Q);
   endtask

   task automatic put_bit(input logic b);
      c_sda = b;    hold(Q);
      c_scl = 1'b1; hold(Q);
      c_scl = 1'b0; hold(Q);
   endtask

   task automatic get_bit(output logic b);
      c_sda = 1'b1; hold(Q);
      c_scl = 1'b1; hold(Q/2);
      b = bus_sda;  hold(Q - Q/2);
      c_scl = 1'b0; hold(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~ack);
   endtask

   task automatic header(input int a, input logic [7:0] hi_junk);
      logic ack;
      bus_start();
      send_byte(dev_byte(1'b0), ack);
      chk("R1 write address ack", int'(ack), 1);
      send_byte(hi_junk, ack);
      chk("R3 high address ack", int'(ack), 1);
      send_byte(8'(a), ack);
      chk("R3 low address ack", int'(ack), 1);
   endtask

   task automatic wait_ready();
      logic ack;
      int tries;
      bus_start();
      send_byte(dev_byte(1'b0), ack);
      bus_stop();
      chk("R8 poll right after commit start is NACKed", int'(ack), 0);
      tries = 0;
      while (!ack && tries < 30) begin
         bus_start();
         send_byte(dev_byte(1'b0), ack);
         bus_stop();
         tries++;
      end
      chk("R8 address acknowledged after commit", int'(ack), 1);
   endtask

   task automatic page_write(input int a, input int n, input logic [7:0] hi_junk);
      logic ack;
      logic [7:0] d;
      int cur;
      header(a, hi_junk);
      cur = a;
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         send_byte(d, ack);
         chk("R4 data byte ack", int'(ack), 1);
         ref_mem[cur] = d;
         cur = page_next(cur);
      end
      bus_stop();
      ref_ptr = cur;
      wait_ready();
   endtask

   task automatic read_run(input int n, input string tag);
      logic [7:0] v;
      for (int i = 0; i < n; i++) begin
         recv_byte(v, i < n - 1);
         chk(tag, int'(v), int'(ref_mem[ref_ptr]));
         ref_ptr = (ref_ptr + 1) % DEPTH;
      end
      bus_stop();
   endtask

   task automatic rand_read(input int a, input int n);
      logic ack;
      header(a, 8'h00);
      bus_start();
      send_byte(dev_byte(1'b1), ack);
      chk("R6 read address ack after repeated start", int'(ack), 1);
      ref_ptr = a;
      read_run(n, "R7 R6 random or sequential read data");
   endtask

   task automatic cur_read(input int n);
      logic ack;
      bus_start();
      send_byte(dev_byte(1'b1), ack);
      chk("R5 current read address ack", int'(ack), 1);
      read_run(n, "R5 current address read data");
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic ack, b;
      int op, a, n;
      void'($urandom(32'h1A2B3C4D));
      hold(5);
      rst_n = 1'b1;
      hold(5);

      // R10: released after reset and immediately addressable
      chk("R10 pull released after reset", int'(sda_pull), 0);
      bus_start();
      send_byte(dev_byte(1'b0), ack);
      bus_stop();
      chk("R10 first address acknowledged", int'(ack), 1);

      // R2: wrong strap bits and wrong family code
      bus_start();
      send_byte({5'b10100, ~STRAP, 1'b0}, ack);
      chk("R2 wrong strap not acknowledged", int'(ack), 0);
      for (int i = 7; i >= 0; i--) put_bit(1'b0);
      get_bit(b);
      chk("R2 following byte left undriven", int'(b), 1);
      bus_stop();
      bus_start();
      send_byte({5'b10110, STRAP, 1'b1}, ack);
      bus_stop();
      chk("R2 wrong family code not acknowledged", int'(ack), 0);

      // fill the whole array with full-page writes (R4, R8)
      for (int p = 0; p < DEPTH / PAGE; p++)
         page_write(p * PAGE, PAGE, 8'h00);

      // R4: page write starting near a page end wraps inside the page
      page_write(PAGE + PAGE - 4, 8, 8'hA7);
      chk("R4 counter after wrapped page write", ref_ptr, PAGE + 4);
      cur_read(2);
      rand_read(PAGE + PAGE - 4, 4);

      // R7: sequential read wraps from the last location to 0
      rand_read(DEPTH - 2, 5);
      cur_read(2);

      // R3: upper address bits are ignored
      page_write(17, 1, 8'hFF);
      rand_read(17, 1);

      // constrained random mix
      for (int it = 0; it < 14; it++) begin
         op = int'($urandom % 3);
         a  = int'($urandom % DEPTH);
         if (op == 0) begin
            n = 1 + int'($urandom % 10);
            page_write(a, n, 8'($urandom));
         end else if (op == 1) begin
            n = 1 + int'($urandom % 6);
            rand_read(a, n);
         end else begin
            n = 1 + int'($urandom % 3);
            cur_read(n);
         end
      end

      chk("R9 pull changes while SCL high", viol, 0);
      summary();
      $finish;
   end

endmodule